// File: doc/BRIEF.md
# Generator-Store Block Address Recorder with Marshal Push

Each core carries one of these buffers. Some stores are tagged as generator stores because they produce data that a later code segment on another core will read. For each such store the buffer keeps the address of the 64-byte cache block it wrote. Untagged stores leave the buffer alone. If a second generator store hits a block already held, no new entry is made. The buffer holds at most 16 block addresses of 48 bits each. Generator stores that find it full are dropped, and a sticky overflow indication is raised.

A marshal command names a destination core. The buffer then sends every recorded block address, oldest first, as push requests on a valid/ready stream. Each request carries the destination core with it. After the last request is accepted, the buffer empties itself and gives a one-cycle completion pulse. A marshal on an empty buffer sends nothing and completes at once. The command input is refused for as long as a drain is running, so a new command waits until the current drain ends.

Top module: `marshal_addr_buf`

## Requirements
- R1: The block address recorded for a store is its physical address with the low 6 offset bits removed, which is `st_paddr[53:6]`. Any two stores inside one 64-byte block record the same 48-bit value.
- R2: A store with `st_gen` low is never recorded.
- R3: A generator store whose block address is already held adds no entry. The block is pushed only once.
- R4: At most 16 entries are held. A generator store with a new block that arrives while the buffer is full is dropped, and `ovf_flag` goes high on the next cycle. The flag stays high until a marshal command is accepted, and it reads low on the cycle after that acceptance.
- R5: An accepted marshal produces one push request for each held entry, in the order the entries were first recorded. Every request carries the command's destination in `push_dest`.
- R6: While `push_valid` is high and `push_ready` is low, the request stays valid and its block and destination do not change.
- R7: In the cycle after the last push is accepted, `done_pulse` is high for one cycle and the buffer is empty. A marshal issued next sends no pushes.
- R8: `msh_ready` is low for the whole drain. A command held on `msh_valid` during the drain is accepted in the first cycle after the drain ends.
- R9: A marshal accepted with no entries held raises `done_pulse` in the next cycle and issues no push.
- R10: A generator store is not recorded if it arrives during a drain or in the same cycle that a marshal command is accepted.
- R11: After reset, `push_valid`, `done_pulse` and `ovf_flag` are low, `msh_ready` is high, and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | A store commits this cycle |
| st_gen | input | 1 | The committing store is a generator store |
| st_paddr | input | 54 | Physical byte address of the store |
| msh_valid | input | 1 | Marshal command request |
| msh_dest | input | 6 | Destination core of the marshal |
| msh_ready | output | 1 | Marshal command can be taken (buffer idle) |
| push_valid | output | 1 | Push request valid |
| push_dest | output | 6 | Destination core of the push |
| push_blk | output | 48 | Block address being pushed |
| push_ready | input | 1 | Push request accepted |
| done_pulse | output | 1 | One-cycle marshal completion |
| ovf_flag | output | 1 | Generator addresses were dropped since the last marshal |

## Verification
The recording path is driven with a mixed table of stores. Generator and plain stores are interleaved, and several stores reuse a block at different byte offsets. The pushed list then shows whether offset stripping, filtering of plain stores and duplicate merging each work. A run of twenty distinct blocks fills the buffer past capacity and checks that exactly the first sixteen are pushed, in order. The same run locates the cycle in which overflow rises and the cycle in which it clears. Drains are run both with `push_ready` held high and with `push_ready` toggling. A stall that moves the data shows up only in the toggling case. A command held through a drain, together with a store injected during the drain, shows up as a completion with no pushes when the held command is taken.

// File: rtl/mab_pkg.sv
package mab_pkg;
   typedef enum logic {
      MAB_IDLE  = 1'b0,
      MAB_DRAIN = 1'b1
   } mab_state_e;
endpackage

// File: rtl/mab_store.sv
// Entry array with append, optional merge of duplicate blocks, and sticky overflow.
module mab_store #(
   parameter int DEPTH = 16,
   parameter int BLK_W = 48,
   parameter bit DEDUP = 1'b1,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [BLK_W-1:0] wr_blk,
   input  logic             clr,
   input  logic             ovf_clr,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [BLK_W-1:0] rd_blk,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);
   logic [BLK_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0] hit;
   logic             any_hit;
   logic             full;
   logic             append;

   generate
      if (DEDUP) begin : g_dedup
         for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
            assign hit[i] = (CNT_W'(i) < count) && (mem[i] == wr_blk);
         end
      end else begin : g_nodedup
         assign hit = '0;
      end
   endgenerate

   assign any_hit = |hit;
   assign full    = (count == CNT_W'(DEPTH));
   assign append  = wr_en && !any_hit && !full;
   assign rd_blk  = mem[rd_idx];

   always_ff @(posedge clk) begin
      if (append) begin
         mem[count[IDX_W-1:0]] <= wr_blk;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         ovf   <= 1'b0;
      end else begin
         if (clr) begin
            count <= '0;
         end else if (append) begin
            count <= count + 1'b1;
         end
         if (ovf_clr) begin
            ovf <= 1'b0;
         end else if (wr_en && !any_hit && full) begin
            ovf <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/mab_drain.sv
// Marshal command acceptance and sequential push of held entries.
module mab_drain
   import mab_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CID_W = 6,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [CID_W-1:0] cmd_dest,
   output logic             cmd_ready,
   output logic             cmd_take,
   input  logic [CNT_W-1:0] count,
   output logic             push_valid,
   output logic [CID_W-1:0] push_dest,
   input  logic             push_ready,
   output logic [IDX_W-1:0] rd_idx,
   output logic             buf_clr,
   output logic             done
);
   mab_state_e       state;
   logic [CID_W-1:0] dest_q;
   logic [IDX_W-1:0] idx_q;
   logic             last;
   logic             fire;

   assign cmd_ready  = (state == MAB_IDLE);
   assign cmd_take   = cmd_valid && cmd_ready;
   assign push_valid = (state == MAB_DRAIN);
   assign push_dest  = dest_q;
   assign rd_idx     = idx_q;
   assign last       = ((CNT_W'(idx_q) + CNT_W'(1)) == count);
   assign fire       = push_valid && push_ready;
   assign buf_clr    = fire && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= MAB_IDLE;
         dest_q <= '0;
         idx_q  <= '0;
         done   <= 1'b0;
      end else begin
         done <= (cmd_take && (count == '0)) || buf_clr;
         case (state)
            MAB_IDLE: begin
               if (cmd_take) begin
                  dest_q <= cmd_dest;
                  idx_q  <= '0;
                  if (count != '0) state <= MAB_DRAIN;
               end
            end
            MAB_DRAIN: begin
               if (fire) begin
                  if (last) state <= MAB_IDLE;
                  else      idx_q <= idx_q + 1'b1;
               end
            end
            default: state <= MAB_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/marshal_addr_buf.sv
module marshal_addr_buf #(
   parameter int DEPTH     = 16,
   parameter int PA_W      = 54,
   parameter int BLK_BYTES = 64,
   parameter int CID_W     = 6,
   parameter bit DEDUP     = 1'b1,
   localparam int OFS_W    = $clog2(BLK_BYTES),
   localparam int BLK_W    = PA_W - OFS_W,
   localparam int CNT_W    = $clog2(DEPTH + 1),
   localparam int IDX_W    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             st_valid,
   input  logic             st_gen,
   input  logic [PA_W-1:0]  st_paddr,
   input  logic             msh_valid,
   input  logic [CID_W-1:0] msh_dest,
   output logic             msh_ready,
   output logic             push_valid,
   output logic [CID_W-1:0] push_dest,
   output logic [BLK_W-1:0] push_blk,
   input  logic             push_ready,
   output logic             done_pulse,
   output logic             ovf_flag
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if ((1 << OFS_W) != BLK_BYTES) begin : g_bad_blk
         $error("BLK_BYTES must be a power of two");
      end
      if (PA_W <= OFS_W) begin : g_bad_pa
         $error("PA_W must exceed block offset width");
      end
      if (CID_W < 1) begin : g_bad_cid
         $error("CID_W must be at least 1");
      end
   endgenerate

   logic             cmd_take;
   logic             wr_en;
   logic             buf_clr;
   logic [CNT_W-1:0] count;
   logic [IDX_W-1:0] rd_idx;

   // recording is frozen while draining and on the cycle a command is taken
   assign wr_en = st_valid && st_gen && msh_ready && !msh_valid;

   mab_store #(
      .DEPTH (DEPTH),
      .BLK_W (BLK_W),
      .DEDUP (DEDUP)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_blk  (st_paddr[PA_W-1:OFS_W]),
      .clr     (buf_clr),
      .ovf_clr (cmd_take),
      .rd_idx  (rd_idx),
      .rd_blk  (push_blk),
      .count   (count),
      .ovf     (ovf_flag)
   );

   mab_drain #(
      .DEPTH (DEPTH),
      .CID_W (CID_W)
   ) u_drain (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (msh_valid),
      .cmd_dest   (msh_dest),
      .cmd_ready  (msh_ready),
      .cmd_take   (cmd_take),
      .count      (count),
      .push_valid (push_valid),
      .push_dest  (push_dest),
      .push_ready (push_ready),
      .rd_idx     (rd_idx),
      .buf_clr    (buf_clr),
      .done       (done_pulse)
   );
endmodule

// File: rtl/mab_chk.sv
module mab_chk #(
   parameter int DEPTH = 16,
   parameter int CID_W = 6,
   parameter int BLK_W = 48
) (
   input logic             clk,
   input logic             rst_n,
   input logic             msh_valid,
   input logic             msh_ready,
   input logic             push_valid,
   input logic [CID_W-1:0] push_dest,
   input logic [BLK_W-1:0] push_blk,
   input logic             push_ready,
   input logic             done_pulse,
   input logic             ovf_flag
);
   localparam int PC_W = $clog2(DEPTH + 2);
   logic [PC_W-1:0] push_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                       push_cnt <= '0;
      else if (done_pulse)              push_cnt <= '0;
      else if (push_valid && push_ready) push_cnt <= push_cnt + 1'b1;
   end

   a_r6_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid && !push_ready |=> push_valid && $stable(push_blk) && $stable(push_dest));

   a_r8_cmd_blocked_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
      push_valid |-> !msh_ready);

   a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> msh_ready && !push_valid);

   a_r9_marshal_reacts: assert property (@(posedge clk) disable iff (!rst_n)
      msh_valid && msh_ready |=> push_valid || done_pulse);

   a_r4_ovf_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      msh_valid && msh_ready |=> !ovf_flag);

   a_r4_push_capacity: assert property (@(posedge clk) disable iff (!rst_n)
      push_cnt <= PC_W'(DEPTH));
endmodule

bind marshal_addr_buf mab_chk #(
   .DEPTH (DEPTH),
   .CID_W (CID_W),
   .BLK_W (BLK_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .msh_valid  (msh_valid),
   .msh_ready  (msh_ready),
   .push_valid (push_valid),
   .push_dest  (push_dest),
   .push_blk   (push_blk),
   .push_ready (push_ready),
   .done_pulse (done_pulse),
   .ovf_flag   (ovf_flag)
);

// File: tb/sim_marshal_addr_buf.sv
`timescale 1ns/1ps
module sim_marshal_addr_buf;
   localparam int PA_W  = 54;
   localparam int BLK_W = 48;
   localparam int CID_W = 6;
   localparam int DEPTH = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             st_valid = 1'b0, st_gen = 1'b0;
   logic [PA_W-1:0]  st_paddr = '0;
   logic             msh_valid = 1'b0;
   logic [CID_W-1:0] msh_dest = '0;
   logic             msh_ready, push_valid, push_ready = 1'b0, done_pulse, ovf_flag;
   logic [CID_W-1:0] push_dest;
   logic [BLK_W-1:0] push_blk;

   int n_cmp = 0, n_bad = 0;
   logic [BLK_W-1:0] q[$];

   always #4 clk = ~clk;

   marshal_addr_buf u0 (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_gen(st_gen), .st_paddr(st_paddr),
      .msh_valid(msh_valid), .msh_dest(msh_dest), .msh_ready(msh_ready),
      .push_valid(push_valid), .push_dest(push_dest), .push_blk(push_blk),
      .push_ready(push_ready), .done_pulse(done_pulse), .ovf_flag(ovf_flag)
   );

   // stimulus table: {generator bit, physical address}
   localparam int NV = 10;
   localparam logic [PA_W:0] VEC [NV] = '{
      {1'b1, 54'h0000_1234_5640},
      {1'b0, 54'h0000_0000_1000},
      {1'b1, 54'h0000_1234_567F},
      {1'b1, 54'h2A5A_5A5A_5A80},
      {1'b0, 54'h2A5A_5A5A_5AC0},
      {1'b1, 54'h0000_0000_0000},
      {1'b1, 54'h2A5A_5A5A_5AA7},
      {1'b1, 54'h3FFF_FFFF_FFFF},
      {1'b0, 54'h0123_4567_8900},
      {1'b1, 54'h0000_0000_003F}
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_store(input bit g, input logic [PA_W-1:0] pa);
      logic [BLK_W-1:0] b;
      bit found;
      b = pa[PA_W-1:6];
      found = 1'b0;
      if (!g) return;
      foreach (q[k]) if (q[k] == b) found = 1'b1;
      if (!found && q.size() < DEPTH) q.push_back(b);
   endtask

   task automatic do_store(input bit g, input logic [PA_W-1:0] pa);
      @(negedge clk);
      st_valid = 1'b1; st_gen = g; st_paddr = pa;
      model_store(g, pa);
      @(negedge clk);
      st_valid = 1'b0; st_gen = 1'b0;
   endtask

   // bp: toggle push_ready; inj: store during accept/drain and hold a second command
   task automatic run_marshal(input logic [CID_W-1:0] d, input bit bp, input bit inj, input string req);
      int got = 0;
      int cyc = 0;
      bit prev_stall = 1'b0;
      logic [BLK_W-1:0] pblk = '0;
      @(negedge clk);
      chk(msh_ready == 1'b1, "R8", msh_ready, 1);
      msh_valid = 1'b1; msh_dest = d;
      if (inj) begin
         st_valid = 1'b1; st_gen = 1'b1; st_paddr = 54'h1555_0000_0040;
      end
      @(negedge clk);
      if (!inj) msh_valid = 1'b0;
      else msh_dest = d ^ 6'h3F;
      while (!done_pulse && cyc < 200) begin
         push_ready = !bp || cyc[0];
         if (inj && cyc == 2) st_valid = 1'b0;
         if (push_valid) begin
            if (prev_stall) chk(push_blk == pblk, "R6", push_blk, pblk);
            chk(push_dest == d, "R5", push_dest, d);
            chk(got < q.size() && push_blk == q[got], req, push_blk, got < q.size() ? q[got] : '1);
            if (cyc == 0) chk(msh_ready == 1'b0, "R8", msh_ready, 0);
            prev_stall = !push_ready;
            pblk = push_blk;
            if (push_ready) got++;
         end
         cyc++;
         @(negedge clk);
      end
      st_valid = 1'b0;
      push_ready = 1'b0;
      chk(done_pulse == 1'b1, "R7", done_pulse, 1);
      chk(got == q.size(), req, got, q.size());
      chk(ovf_flag == 1'b0, "R4", ovf_flag, 0);
      q.delete();
      if (inj) begin
         // held command taken at this edge; buffer must be empty (R7, R8, R10)
         chk(msh_ready == 1'b1, "R8", msh_ready, 1);
         @(negedge clk);
         msh_valid = 1'b0;
         chk(done_pulse == 1'b1 && push_valid == 1'b0, "R10", {push_valid, done_pulse}, 2'b01);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(push_valid == 1'b0, "R11", push_valid, 0);
      chk(done_pulse == 1'b0, "R11", done_pulse, 0);
      chk(ovf_flag == 1'b0, "R11", ovf_flag, 0);
      chk(msh_ready == 1'b1, "R11", msh_ready, 1);

      // R9: empty marshal
      run_marshal(6'h05, 1'b0, 1'b0, "R9");

      // table walk: R1 alignment, R2 plain stores, R3 duplicates
      for (int i = 0; i < NV; i++) begin
         do_store(VEC[i][PA_W], VEC[i][PA_W-1:0]);
         chk(ovf_flag == 1'b0, "R4", ovf_flag, 0);
      end
      chk(q.size() == 4, "R3", q.size(), 4);
      run_marshal(6'h2C, 1'b0, 1'b0, "R1");

      // R6 with back-pressure, plus R10 and held command
      do_store(1'b1, 54'h0000_0ABC_0000);
      do_store(1'b1, 54'h0000_0ABC_0040);
      do_store(1'b1, 54'h0000_0ABC_0080);
      run_marshal(6'h11, 1'b1, 1'b1, "R5");

      // R4: overflow past 16 entries
      for (int i = 0; i < 20; i++) begin
         do_store(1'b1, PA_W'(i) << 6 | 54'h1000_0000_0000);
         if (i == DEPTH - 1) chk(ovf_flag == 1'b0, "R4", ovf_flag, 0);
         if (i == DEPTH)     chk(ovf_flag == 1'b1, "R4", ovf_flag, 1);
      end
      chk(ovf_flag == 1'b1, "R4", ovf_flag, 1);
      run_marshal(6'h3F, 1'b1, 1'b0, "R4");

      // R7: buffer empty after drain
      run_marshal(6'h01, 1'b0, 1'b0, "R7");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule